// File: doc/BRIEF.md
# GF(2^128) Multiplier with Selectable Partial-Product Decomposition

The block multiplies two 128-bit elements of GF(2^128), the core operation of a GCM hash engine. Each operand is split into 64-bit halves. One shared 64x64 carry-less multiplier is stepped through a short sequence of partial products. The partials are then merged into a 256-bit carry-less product, which is folded back to 128 bits modulo x^128 + x^7 + x^2 + x + 1.

A mode input chooses the decomposition. The straightforward method uses four half-width products. The Karatsuba method uses three half-width products and spends a few extra XORs to save one multiplier pass. A start pulse captures the operands and the mode. After a fixed latency the result appears on the product output, and a one-cycle done pulse marks it. The block serves one operation at a time. Chaining of hash blocks, additional authenticated data and the length block belong to the surrounding logic.

Top module: `gf128_kmul`

## Requirements
- R1: prod_o equals a_i times b_i in GF(2^128) modulo x^128 + x^7 + x^2 + x + 1, where bit i of every 128-bit vector is the coefficient of x^i.
- R2: With mode_i = 0 (four-product method), done_o rises 5 clock edges after the edge that accepted start_i, and prod_o then holds the R1 result.
- R3: With mode_i = 1 (three-product Karatsuba method), done_o rises 4 clock edges after the accepting edge, and prod_o then holds the R1 result.
- R4: For the same operands, both modes give the same product.
- R5: done_o is high for exactly one cycle per accepted operation.
- R6: prod_o keeps its last result until the next done_o pulse.
- R7: While an operation is in progress, start_i is ignored. The running result and its latency are unchanged, and no extra done_o pulse follows.
- R8: a_i, b_i and mode_i are sampled only on the accepting edge. Later changes to them do not affect the running operation.
- R9: During reset, done_o is 0 and prod_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; accepted only when idle |
| mode_i | input | 1 | 0: four-product method, 1: three-product Karatsuba method |
| a_i | input | 128 | First operand, bit i = coefficient of x^i |
| b_i | input | 128 | Second operand, bit i = coefficient of x^i |
| prod_o | output | 128 | Reduced product |
| done_o | output | 1 | One-cycle pulse when prod_o is updated |

## Verification
The bench sweeps single-term operands x^i times x^j across all i and across j values on both sides of the half boundary and at the top degree. A design that swaps the two middle partials or misplaces the 64-bit shift gives a wrong product exactly where a term crosses bit 64. Top-degree pairs such as x^127 * x^127 exercise the second reduction fold. A design that drops that fold leaves bits near x^7 wrong. Random operands are run in both modes and compared against each other and against a bit-serial reference; the all-ones case stresses the Karatsuba middle-term XOR. Inputs are disturbed and start is re-pulsed mid-operation, which catches a design that re-samples operands or queues a second request.

// File: rtl/gf128_pkg.sv
package gf128_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_RED  = 2'd2
  } kmul_state_e;

  localparam logic MODE_SCHOOL = 1'b0;
  localparam logic MODE_KARA   = 1'b1;
  localparam int   STEP_W      = 2;
endpackage

// File: rtl/gf128_clmul.sv
module gf128_clmul #(
  parameter int HALF_W = 64,
  localparam int PW = 2 * HALF_W
) (
  input  logic [HALF_W-1:0] x_i,
  input  logic [HALF_W-1:0] y_i,
  output logic [PW-1:0]     p_o
);
  always_comb begin
    p_o = '0;
    for (int k = 0; k < HALF_W; k++) begin
      if (y_i[k]) p_o = p_o ^ ({{HALF_W{1'b0}}, x_i} << k);
    end
  end
endmodule

// File: rtl/gf128_reduce.sv
module gf128_reduce #(
  parameter int W = 128,
  parameter int PLW = 8,
  parameter logic [PLW-1:0] POLY_LO = 8'h87
) (
  input  logic [2*W-1:0] full_i,
  output logic [W-1:0]   red_o
);
  logic [W-1:0]     hi, lo;
  logic [W+PLW-1:0] fold1;
  logic [PLW-1:0]   ovf;
  logic [W-1:0]     fold2;

  assign hi = full_i[2*W-1:W];
  assign lo = full_i[W-1:0];

  // first fold: hi * x^W == hi * POLY_LO
  always_comb begin
    fold1 = '0;
    for (int k = 0; k < PLW; k++) begin
      if (POLY_LO[k]) fold1 = fold1 ^ ({{PLW{1'b0}}, hi} << k);
    end
  end

  assign ovf = fold1[W+PLW-1:W];

  // second fold absorbs the few bits pushed past x^(W-1)
  always_comb begin
    fold2 = '0;
    for (int k = 0; k < PLW; k++) begin
      if (POLY_LO[k]) fold2 = fold2 ^ ({{(W-PLW){1'b0}}, ovf} << k);
    end
  end

  assign red_o = lo ^ fold1[W-1:0] ^ fold2;
endmodule

// File: rtl/gf128_kmul_ctrl.sv
module gf128_kmul_ctrl
  import gf128_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_q_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              mul_en_o,
  output logic              red_o,
  output logic [STEP_W-1:0] step_o
);
  kmul_state_e state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic last_step;

  assign last_step = (mode_q_i == MODE_KARA) ? (step_q == STEP_W'(2)) : (step_q == STEP_W'(3));
  assign accept_o  = start_i && (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign mul_en_o  = (state_q == ST_MUL);
  assign red_o     = (state_q == ST_RED);
  assign step_o    = step_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin state_d = ST_MUL; step_d = '0; end
      ST_MUL: begin
        if (last_step) state_d = ST_RED;
        else step_d = step_q + STEP_W'(1);
      end
      ST_RED: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end
endmodule

// File: rtl/gf128_kmul.sv
module gf128_kmul
  import gf128_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int PLW = 8,
  parameter logic [PLW-1:0] POLY_LO = 8'h87,
  localparam int W = 2 * HALF_W,
  localparam int NPP = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_o,
  output logic         done_o
);
  logic [W-1:0] a_q, b_q;
  logic         mode_q;
  logic         ctl_accept, ctl_busy, ctl_mul_en, ctl_red;
  logic [STEP_W-1:0] ctl_step;
  logic [HALF_W-1:0] op_x, op_y;
  logic [W-1:0]   mul_res;
  logic [W-1:0]   pp_q [NPP];
  logic [2*W-1:0] full;
  logic [W-1:0]   red;

  gf128_kmul_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_q_i (mode_q),
    .accept_o (ctl_accept),
    .busy_o   (ctl_busy),
    .mul_en_o (ctl_mul_en),
    .red_o    (ctl_red),
    .step_o   (ctl_step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= MODE_SCHOOL;
    end else if (ctl_accept) begin
      a_q    <= a_i;
      b_q    <= b_i;
      mode_q <= mode_i;
    end
  end

  // operand pair per step
  always_comb begin
    op_x = '0;
    op_y = '0;
    if (mode_q == MODE_SCHOOL) begin
      unique case (ctl_step)
        2'd0: begin op_x = a_q[HALF_W-1:0]; op_y = b_q[HALF_W-1:0]; end
        2'd1: begin op_x = a_q[W-1:HALF_W]; op_y = b_q[W-1:HALF_W]; end
        2'd2: begin op_x = a_q[HALF_W-1:0]; op_y = b_q[W-1:HALF_W]; end
        default: begin op_x = a_q[W-1:HALF_W]; op_y = b_q[HALF_W-1:0]; end
      endcase
    end else begin
      unique case (ctl_step)
        2'd0: begin op_x = a_q[W-1:HALF_W]; op_y = b_q[W-1:HALF_W]; end
        2'd1: begin op_x = a_q[HALF_W-1:0]; op_y = b_q[HALF_W-1:0]; end
        default: begin
          op_x = a_q[HALF_W-1:0] ^ a_q[W-1:HALF_W];
          op_y = b_q[HALF_W-1:0] ^ b_q[W-1:HALF_W];
        end
      endcase
    end
  end

  gf128_clmul #(.HALF_W(HALF_W)) u_clmul (
    .x_i (op_x),
    .y_i (op_y),
    .p_o (mul_res)
  );

  for (genvar g = 0; g < NPP; g++) begin : g_pp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pp_q[g] <= '0;
      else if (ctl_mul_en && ctl_step == STEP_W'(g)) pp_q[g] <= mul_res;
    end
  end

  // school: pp0=lo*lo, pp1=hi*hi, pp2/pp3 cross; kara: pp0=hi*hi, pp1=lo*lo, pp2=mid
  always_comb begin
    if (mode_q == MODE_SCHOOL)
      full = {pp_q[1], {W{1'b0}}}
           ^ {{HALF_W{1'b0}}, pp_q[2] ^ pp_q[3], {HALF_W{1'b0}}}
           ^ {{W{1'b0}}, pp_q[0]};
    else
      full = {pp_q[0], {W{1'b0}}}
           ^ {{HALF_W{1'b0}}, pp_q[0] ^ pp_q[1] ^ pp_q[2], {HALF_W{1'b0}}}
           ^ {{W{1'b0}}, pp_q[1]};
  end

  gf128_reduce #(.W(W), .PLW(PLW), .POLY_LO(POLY_LO)) u_reduce (
    .full_i (full),
    .red_o  (red)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= ctl_red;
      if (ctl_red) prod_o <= red;
    end
  end
endmodule

// File: rtl/gf128_kmul_chk.sv
module gf128_kmul_chk #(
  parameter int W = 128
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         mode_i,
  input logic         accept,
  input logic         busy,
  input logic         mode_q,
  input logic [W-1:0] prod_o,
  input logic         done_o
);
  p_lat_school_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !mode_q |-> $past(accept, 6))
    else $error("p_lat_school_r2");

  p_lat_kara_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q |-> $past(accept, 5))
    else $error("p_lat_kara_r3");

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("p_done_pulse_r5");

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(prod_o))
    else $error("p_hold_r6");

  p_ignore_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && start_i |=> $stable(mode_q))
    else $error("p_ignore_busy_r7");

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> mode_q == $past(mode_i))
    else $error("p_capture_r8");

  always_comb begin
    if (!rst_ni) begin
      p_reset_r9: assert (!done_o && prod_o == '0) else $error("p_reset_r9");
    end
  end
endmodule

bind gf128_kmul gf128_kmul_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .mode_i  (mode_i),
  .accept  (ctl_accept),
  .busy    (ctl_busy),
  .mode_q  (mode_q),
  .prod_o  (prod_o),
  .done_o  (done_o)
);

// File: tb/gf128_kmul_bench.sv
`timescale 1ns/1ps
module gf128_kmul_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [127:0] a_i = '0, b_i = '0;
  logic [127:0] prod_o;
  logic         done_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gf128_kmul u_gf128_kmul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .a_i(a_i), .b_i(b_i), .prod_o(prod_o), .done_o(done_o)
  );

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0, v = a;
    logic c;
    for (int i = 0; i < 128; i++) begin
      if (b[i]) z ^= v;
      c = v[127];
      v = v << 1;
      if (c) v ^= 128'h87;
    end
    return z;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic m,
                        input bit poke, output logic [127:0] got);
    logic [127:0] exp;
    int n;
    int lat;
    exp = ref_mul(a, b);
    lat = m ? 4 : 5;
    a_i = a; b_i = b; mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin a_i = ~a; b_i = rnd128(); mode_i = ~m; end
    n = 0;
    while (!done_o && n < 20) begin
      start_i = (poke && n == 1);
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    chk(n == lat, m ? "R3 latency" : "R2 latency", 128'(n), 128'(lat));
    if (poke) chk(prod_o == exp, "R8 operands held", prod_o, exp);
    else chk(prod_o == exp, m ? "R1 R3 product" : "R1 R2 product", prod_o, exp);
    got = prod_o;
    @(negedge clk);
    chk(!done_o, "R5 pulse width", 128'(done_o), 128'(0));
    chk(prod_o == exp, "R6 hold", prod_o, exp);
    if (poke) begin
      logic seen = 1'b0;
      for (int k = 0; k < 7; k++) begin
        @(negedge clk);
        seen |= done_o;
      end
      chk(!seen, "R7 no extra done", 128'(seen), 128'(0));
      chk(prod_o == exp, "R7 result kept", prod_o, exp);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] r0, r1, a, b;
    int js[5] = '{0, 1, 63, 64, 127};
    repeat (3) @(negedge clk);
    chk(!done_o, "R9 reset done", 128'(done_o), 128'(0));
    chk(prod_o == '0, "R9 reset prod", prod_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 128; i++)
        for (int j = 0; j < 5; j++)
          run_op(128'(1) << i, 128'(1) << js[j], m[0], 1'b0, r0);

    run_op('1, '1, 1'b0, 1'b0, r0);
    run_op('1, '1, 1'b1, 1'b0, r1);
    chk(r0 == r1, "R4 all ones", r1, r0);

    for (int t = 0; t < 150; t++) begin
      a = rnd128();
      b = rnd128();
      run_op(a, b, 1'b0, 1'b0, r0);
      run_op(a, b, 1'b1, 1'b0, r1);
      chk(r0 == r1, "R4 modes agree", r1, r0);
    end

    for (int t = 0; t < 20; t++) begin
      run_op(rnd128(), rnd128(), t[0], 1'b1, r0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule